// File: doc/BRIEF.md
# Receive Address Remap Unit

This block sits on the receive path between the link front end and system memory. Every incoming transaction carries a 32-bit destination address and a 32-bit payload. The block rewrites the address according to a programmable remap mode and hands the packet on one cycle later, with its strobe and payload delayed by the same amount.

Two registers, a configuration word and an offset word, hold the settings. Software reaches them through a small memory-mapped port that is decoded on the low 20 address bits. The upper 12 bits of any full address are a node identifier. In the static mode a per-bit select mask swaps chosen bits of that 12-bit node field for a programmed pattern. In the dynamic mode the address is moved to a programmable memory base: the block subtracts the node's own base and adds the offset word.

Top module: `rx_addr_remap`

## Requirements
- R1: While reset is low and on the first cycle after it, out_valid is 0. Both registers read back as 0, which means mode 00, pass-through.
- R2: With mode 00 (config bits [3:2] = 00), out_addr equals in_addr. out_valid and out_data equal in_valid and in_data from one clock earlier.
- R3: With mode 01, out_addr[31:20] = (in_addr[31:20] & ~sel) | (pat & sel) and out_addr[19:0] = in_addr[19:0]. Here sel is config bits [15:4] and pat is config bits [27:16].
- R4: With mode 10, out_addr = in_addr - {node_id, 20'h0} + offset, taken modulo 2^32.
- R5: With mode 11, out_addr equals in_addr.
- R6: Config bit 28 is stored and read back unchanged, and it has no effect on remapping.
- R7: A write with reg_we=1 to local offset 0xF0300 loads the configuration word. A write to 0xF030C loads the offset word. A read of either returns its full 32 bits on reg_rdata one cycle after the request. A read of any other offset returns 0. A write to any other offset changes neither register.
- R8: A packet presented in the same cycle as a register write still uses the old settings. A packet presented in the next cycle uses the new settings.
- R9: Every in_valid cycle produces exactly one out_valid cycle one clock later, and no out_valid appears without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 12 | This node's identifier, used as the base removed in dynamic mode |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 20 | Local register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after a read request |
| in_valid | input | 1 | Incoming packet strobe |
| in_addr | input | 32 | Incoming destination address |
| in_data | input | 32 | Incoming payload |
| out_valid | output | 1 | Outgoing packet strobe |
| out_addr | output | 32 | Remapped destination address |
| out_data | output | 32 | Payload, delayed to match |

## Verification
A packet presented before a rising edge appears on the outputs right after that edge, so each packet result is due exactly one cycle after it is driven. Read data follows the same one-cycle rule. The bench drives inputs on falling edges and sends each expected packet, computed from its own copy of the registers, into a queue. A monitor pops that queue on the next falling edge whenever out_valid is high, so any extra, missing or late packet shows up as a mismatch. Register reads are sampled one falling edge after the request. The same-cycle write case pushes its expected result from the old register copy before that copy is updated.

// File: rtl/rx_remap_pkg.sv
package rx_remap_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int NODE_W    = 12;
    localparam int LOCAL_W   = 20;
    localparam int MODE_LSB  = 2;
    localparam int SEL_LSB   = 4;
    localparam int PAT_LSB   = 16;
    localparam logic [LOCAL_W-1:0] CFG_LOCAL = 20'hF0300;
    localparam logic [LOCAL_W-1:0] OFS_LOCAL = 20'hF030C;

    typedef enum logic [1:0] {
        MAP_PASS    = 2'b00,
        MAP_STATIC  = 2'b01,
        MAP_DYNAMIC = 2'b10,
        MAP_RSVD    = 2'b11
    } map_mode_e;
endpackage

// File: rtl/rx_remap_regs.sv
module rx_remap_regs
    import rx_remap_pkg::*;
#(
    parameter int RW = 32,
    parameter int LW = 20,
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [LW-1:0] reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output map_mode_e     mode,
    output logic [NW-1:0] sel_mask,
    output logic [NW-1:0] pattern,
    output logic [RW-1:0] offset
);
    typedef struct packed {
        logic [RW-1:0] cfg;
        logic [RW-1:0] ofs;
        logic [RW-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit_cfg, hit_ofs;

    always_comb begin
        hit_cfg = (reg_addr == LW'(CFG_LOCAL));
        hit_ofs = (reg_addr == LW'(OFS_LOCAL));
        st_d    = st_q;
        if (reg_en && reg_we) begin
            if (hit_cfg) st_d.cfg = reg_wdata;
            if (hit_ofs) st_d.ofs = reg_wdata;
        end
        if (reg_en && !reg_we) begin
            if (hit_cfg)      st_d.rdata = st_q.cfg;
            else if (hit_ofs) st_d.rdata = st_q.ofs;
            else              st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign mode      = map_mode_e'(st_q.cfg[MODE_LSB +: 2]);
    assign sel_mask  = st_q.cfg[SEL_LSB +: NW];
    assign pattern   = st_q.cfg[PAT_LSB +: NW];
    assign offset    = st_q.ofs;

    // R7: an unmapped read returns zero one cycle later
    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr != LW'(CFG_LOCAL) && reg_addr != LW'(OFS_LOCAL))
        |=> (reg_rdata == '0));

    // R7: an offset write shows up in the offset word next cycle
    assert_offset_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == LW'(OFS_LOCAL)) |=> (offset == $past(reg_wdata)));

    // R7: no access leaves the settings untouched
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> ($stable(offset) && $stable(mode) && $stable(sel_mask) && $stable(pattern)));
endmodule

// File: rtl/rx_remap_calc.sv
module rx_remap_calc
    import rx_remap_pkg::*;
#(
    parameter int AW = 32,
    parameter int NW = 12
) (
    input  map_mode_e     mode,
    input  logic [NW-1:0] sel_mask,
    input  logic [NW-1:0] pattern,
    input  logic [AW-1:0] offset,
    input  logic [NW-1:0] node_id,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    localparam int LOW_W = AW - NW;

    logic [NW-1:0] merged_hi;
    logic [AW-1:0] node_base;
    logic [AW-1:0] moved;

    for (genvar b = 0; b < NW; b++) begin : g_merge
        assign merged_hi[b] = sel_mask[b] ? pattern[b] : addr_in[LOW_W + b];
    end

    assign node_base = {node_id, {LOW_W{1'b0}}};
    assign moved     = addr_in - node_base + offset;

    always_comb begin
        unique case (mode)
            MAP_STATIC:  addr_out = {merged_hi, addr_in[LOW_W-1:0]};
            MAP_DYNAMIC: addr_out = moved;
            default:     addr_out = addr_in;
        endcase
    end
endmodule

// File: rtl/rx_remap_pipe.sv
module rx_remap_pipe #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.addr = in_addr;
            st_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;
    assign out_data  = st_q.data;

    // R9: one output strobe per input strobe, one cycle later
    assert_strobe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: payload travels with its strobe
    assert_payload_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data == $past(in_data)));
endmodule

// File: rtl/rx_addr_remap.sv
module rx_addr_remap
    import rx_remap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NODE_W-1:0]   node_id,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [LOCAL_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                in_valid,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [DATA_W-1:0]   out_data
);
    map_mode_e          mode;
    logic [NODE_W-1:0]  sel_mask, pattern;
    logic [ADDR_W-1:0]  offset;
    logic [ADDR_W-1:0]  mapped;

    rx_remap_regs #(.RW(DATA_W), .LW(LOCAL_W), .NW(NODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mode(mode), .sel_mask(sel_mask), .pattern(pattern), .offset(offset)
    );

    rx_remap_calc #(.AW(ADDR_W), .NW(NODE_W)) u_calc (
        .mode(mode), .sel_mask(sel_mask), .pattern(pattern), .offset(offset),
        .node_id(node_id), .addr_in(in_addr), .addr_out(mapped)
    );

    rx_remap_pipe #(.AW(ADDR_W), .DW(DATA_W)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_addr(mapped), .in_data(in_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
    );

    // R3: low address bits pass in static mode
    assert_static_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MAP_STATIC) |=>
        (out_addr[ADDR_W-NODE_W-1:0] == $past(in_addr[ADDR_W-NODE_W-1:0])));
    // R2: pass-through leaves the address alone
    assert_pass_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MAP_PASS) |=> (out_addr == $past(in_addr)));
    // R5: reserved mode also passes through
    assert_rsvd_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MAP_RSVD) |=> (out_addr == $past(in_addr)));
endmodule

// File: tb/rx_addr_remap_tb.sv
module rx_addr_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] node_id = 12'h810;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [19:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0, in_data = '0;
    logic        out_valid;
    logic [31:0] out_addr, out_data;

    always #10 clk = ~clk;

    rx_addr_remap dut_i (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m_cfg = '0, m_ofs = '0;
    logic [31:0] q_addr[$], q_data[$];
    string       q_tag[$];

    function automatic logic [31:0] model(input logic [31:0] a);
        logic [11:0] sel, pat;
        sel = m_cfg[15:4];
        pat = m_cfg[27:16];
        case (m_cfg[3:2])
            2'b01:   return {(a[31:20] & ~sel) | (pat & sel), a[19:0]};
            2'b10:   return a - {node_id, 20'h0} + m_ofs;
            default: return a;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pops on each output strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_addr.size() == 0) begin
                check("R9 spurious out_valid", 32'd1, 32'd0);
            end else begin
                string t;
                logic [31:0] ea, ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                t  = q_tag.pop_front();
                check({t, " addr"}, out_addr, ea);
                check({t, " data"}, out_data, ed);
            end
        end
    end

    task automatic pkt(input logic [31:0] a, input logic [31:0] d, input string tag);
        in_valid = 1'b1; in_addr = a; in_data = d;
        q_addr.push_back(model(a)); q_data.push_back(d); q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] v);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        if (a == 20'hF0300) m_cfg = v;
        if (a == 20'hF030C) m_ofs = v;
    endtask

    task automatic rd(input logic [19:0] a, input logic [31:0] exp, input string tag);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        rd(20'hF0300, 32'h0, "R1 config reset");
        rd(20'hF030C, 32'h0, "R1 offset reset");
        pkt(32'h8101_2340, 32'hAAAA_0001, "R1 default pass");
        idle(2);

        // R2 back-to-back pass-through burst
        pkt(32'h0000_0004, 32'h1111_0000, "R2 pass a");
        pkt(32'hFFFF_FFFC, 32'h2222_0000, "R2 pass b");
        pkt(32'h8100_0000, 32'h3333_0000, "R2 pass c");
        idle(2);

        // R3 static remap
        wr(20'hF0300, {4'h0, 12'hABC, 12'hF0F, 2'b01, 2'b00});
        rd(20'hF0300, {4'h0, 12'hABC, 12'hF0F, 2'b01, 2'b00}, "R7 config readback");
        pkt(32'h1234_5678, 32'h0000_0001, "R3 static partial mask");
        wr(20'hF0300, {4'h0, 12'h5A5, 12'hFFF, 2'b01, 2'b00});
        pkt(32'h8109_9999, 32'h0000_0002, "R3 static full mask");
        wr(20'hF0300, {4'h0, 12'h5A5, 12'h000, 2'b01, 2'b00});
        pkt(32'h8109_9999, 32'h0000_0003, "R3 static empty mask");
        idle(2);

        // R4 dynamic remap
        wr(20'hF030C, 32'h3E00_0000);
        rd(20'hF030C, 32'h3E00_0000, "R7 offset readback");
        wr(20'hF0300, 32'h0000_0008);
        pkt(32'h8100_1000, 32'h0000_0004, "R4 dynamic in-node");
        pkt(32'h0000_0010, 32'h0000_0005, "R4 dynamic wrap");
        idle(2);

        // R5 reserved mode
        wr(20'hF0300, {4'h0, 12'hFFF, 12'hFFF, 2'b11, 2'b00});
        pkt(32'h8102_0000, 32'h0000_0006, "R5 mode 11 pass");
        idle(2);

        // R6 bit 28 stored, no effect
        wr(20'hF0300, 32'h1000_0000);
        rd(20'hF0300, 32'h1000_0000, "R6 bit28 readback");
        pkt(32'h8103_0000, 32'h0000_0007, "R6 bit28 pass");
        idle(2);

        // R7 unmapped access
        wr(20'hF0304, 32'hDEAD_BEEF);
        rd(20'hF0304, 32'h0, "R7 unmapped read");
        rd(20'hF0300, 32'h1000_0000, "R7 config kept");
        rd(20'hF030C, 32'h3E00_0000, "R7 offset kept");

        // R8 write and packet in the same cycle
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 20'hF0300; reg_wdata = 32'h0000_0008;
        in_valid = 1'b1; in_addr = 32'h8104_0000; in_data = 32'h0000_0008;
        q_addr.push_back(model(32'h8104_0000)); q_data.push_back(32'h0000_0008);
        q_tag.push_back("R8 same-cycle old setting");
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; in_valid = 1'b0;
        m_cfg = 32'h0000_0008;
        pkt(32'h8104_0000, 32'h0000_0009, "R8 next-cycle new setting");
        idle(3);

        check("R9 all packets delivered", q_addr.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule